// File: doc/BRIEF.md
# Interrupt Priority Status Register Unit

This block holds an 8-bit processor status word. It decides whether pending maskable interrupt requests may be acknowledged. Each request carries a 2-bit priority level, where a lower number means a more urgent request. A 2-bit in-service threshold inside the status word sets which levels are accepted. Alongside it, a global enable bit gates every maskable request. When a request is accepted, the block does three things in one clock edge: it saves the current word on an internal 8-entry stack, clears the enable bit and lowers the threshold. One cycle later it emits a single-cycle acknowledge pulse that carries the winning index and its level.

Software-side strobes drive the remaining operations: enable and disable, whole-byte write, single-bit set and clear, software break, save, and three restore strobes (plain restore, return from interrupt, return from break). The zero, carry, auxiliary-carry and two bank-select bits are only stored here. Nothing at the edge carries a data stream. The acknowledge is a plain pulse with no ready and no back-pressure, and every other pin is plain control or status.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word reads 0x06, the acknowledge pulse, both error flags and the stack are clear.
- R2: Status word bit 7 is the interrupt enable, bits 2:1 the in-service threshold, bits 6, 4, 3, 0 are stored only; a whole-byte write loads all eight bits and reads back unchanged.
- R3: A bit-set or bit-clear strobe changes only the bit chosen by the 3-bit select and leaves the other seven bits as they were.
- R4: The enable strobe sets bit 7; the disable strobe clears it.
- R5: A pending request is eligible only when bit 7 is 1 and its level is numerically less than or equal to the threshold (11 accepts all levels, 00 only level 0); with no eligible request no acknowledge occurs.
- R6: Among eligible requests the lowest level wins, with ties going to the lowest index; the acknowledge output is high for exactly one cycle, the cycle after the decision, carrying the winner's index and level.
- R7: On acknowledge the old word is pushed, bit 7 is cleared and the threshold becomes level minus one, or 00 for level 0.
- R8: A software break pushes the word and clears bit 7, leaving the threshold unchanged.
- R9: The save strobe pushes the word without changing it; the restore, return-from-interrupt and return-from-break strobes each pop the most recently saved word into the status word.
- R10: The stack holds 8 words; a save or break with a full stack sets a sticky overflow flag and leaves the word unchanged, and no request is acknowledged while the stack is full.
- R11: A restore with an empty stack sets a sticky underflow flag and leaves the word unchanged.
- R12: One operation takes effect per cycle, in the order: acknowledge, break, restore, save, byte write, bit set, bit clear, enable, disable; a lower operation asserted in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pending | input | NUM_REQ | Pending flag per request |
| req_level | input | 2*NUM_REQ | Level of request i in bits [2i+1:2i] |
| ei_strobe | input | 1 | Set the enable bit |
| di_strobe | input | 1 | Clear the enable bit |
| wr_en | input | 1 | Whole-byte write |
| wr_data | input | 8 | Byte to write |
| bit_set | input | 1 | Set the selected bit |
| bit_clr | input | 1 | Clear the selected bit |
| bit_sel | input | 3 | Bit position for set or clear |
| brk_strobe | input | 1 | Software break |
| push_strobe | input | 1 | Save the word on the stack |
| pop_strobe | input | 1 | Restore the word from the stack |
| reti_strobe | input | 1 | Return from interrupt (restore) |
| retb_strobe | input | 1 | Return from break (restore) |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_index | output | IDX_W | Index of the acknowledged request |
| ack_level | output | 2 | Level of the acknowledged request |
| status_word | output | 8 | Current status word |
| ovf_err | output | 1 | Sticky stack overflow |
| unf_err | output | 1 | Sticky stack underflow |

## Verification
On every cycle the checker confirms four things about an acknowledge: it lasts one cycle, it was allowed by the enable bit and threshold of the previous cycle, it leaves the enable bit clear and it installs level minus one as the threshold. The checker also holds the error flags sticky and the word unchanged on the cycle either flag rises. Several behaviours show only in the bench's scenarios, with the scoreboard matching each acknowledge against its prediction. These are which of several simultaneous requests wins, last-in-first-out order across nested interrupts and breaks, dropping of lower-ranked strobes in a shared cycle, and withholding of acknowledges on a full stack.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int SW_W     = 8;
  localparam int LVL_W    = 2;
  localparam int IE_POS   = 7;
  localparam int THR_HI   = 2;
  localparam int THR_LO   = 1;
  localparam logic [SW_W-1:0] SW_RESET = 8'h06;

  typedef enum logic [3:0] {
    OP_NONE, OP_ACK, OP_BRK, OP_RESTORE, OP_SAVE,
    OP_WRITE, OP_SET, OP_CLR, OP_EN, OP_DIS
  } sw_op_e;

  // Threshold installed after accepting a request of the given level.
  function automatic logic [LVL_W-1:0] thr_after(input logic [LVL_W-1:0] lvl);
    return (lvl == '0) ? '0 : lvl - LVL_W'(1);
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_status_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REQ-1:0]       req_pending,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  logic                     enable,
  input  logic [LVL_W-1:0]         threshold,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  logic [NUM_REQ-1:0] elig;
  logic [LVL_W-1:0]   lvl [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_elig
    assign lvl[g]  = req_level[g*LVL_W +: LVL_W];
    assign elig[g] = enable && req_pending[g] && (lvl[g] <= threshold);
  end

  // Scan upward; a later index replaces only on a strictly lower level.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (!found || lvl[i] < win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/status_lifo.sv
module status_lifo #(
  parameter  int WIDTH  = 8,
  parameter  int DEPTH  = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0]  mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign wr_ptr   = ADDR_W'(cnt_q);
  assign rd_ptr   = ADDR_W'(cnt_q - CNT_W'(1));
  assign top_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_en && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (push_en && !full)  cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_en && !empty)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter  int NUM_REQ   = 4,
  parameter  int STK_DEPTH = 8,
  localparam int IDX_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_pending,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  logic                     ei_strobe,
  input  logic                     di_strobe,
  input  logic                     wr_en,
  input  logic [SW_W-1:0]          wr_data,
  input  logic                     bit_set,
  input  logic                     bit_clr,
  input  logic [2:0]               bit_sel,
  input  logic                     brk_strobe,
  input  logic                     push_strobe,
  input  logic                     pop_strobe,
  input  logic                     reti_strobe,
  input  logic                     retb_strobe,
  output logic                     ack_valid,
  output logic [IDX_W-1:0]         ack_index,
  output logic [LVL_W-1:0]         ack_level,
  output logic [SW_W-1:0]          status_word,
  output logic                     ovf_err,
  output logic                     unf_err
);
  logic [SW_W-1:0]  sw_q, sw_d;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             stk_full, stk_empty, push_en, pop_en;
  logic [SW_W-1:0]  stk_top;
  logic             ovf_set, unf_set, ack_d;
  sw_op_e           op;

  irq_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
    .req_pending (req_pending),
    .req_level   (req_level),
    .enable      (sw_q[IE_POS]),
    .threshold   (sw_q[THR_HI:THR_LO]),
    .found       (found),
    .win_idx     (win_idx),
    .win_lvl     (win_lvl)
  );

  status_lifo #(.WIDTH(SW_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .push_data (sw_q),
    .top_data  (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  // Fixed precedence: one operation per cycle.
  always_comb begin
    if (found && !stk_full)                         op = OP_ACK;
    else if (brk_strobe)                            op = OP_BRK;
    else if (pop_strobe || reti_strobe || retb_strobe) op = OP_RESTORE;
    else if (push_strobe)                           op = OP_SAVE;
    else if (wr_en)                                 op = OP_WRITE;
    else if (bit_set)                               op = OP_SET;
    else if (bit_clr)                               op = OP_CLR;
    else if (ei_strobe)                             op = OP_EN;
    else if (di_strobe)                             op = OP_DIS;
    else                                            op = OP_NONE;
  end

  always_comb begin
    sw_d    = sw_q;
    push_en = 1'b0;
    pop_en  = 1'b0;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    ack_d   = 1'b0;
    unique case (op)
      OP_ACK: begin
        push_en              = 1'b1;
        ack_d                = 1'b1;
        sw_d[IE_POS]         = 1'b0;
        sw_d[THR_HI:THR_LO]  = thr_after(win_lvl);
      end
      OP_BRK: begin
        if (stk_full) ovf_set = 1'b1;
        else begin
          push_en      = 1'b1;
          sw_d[IE_POS] = 1'b0;
        end
      end
      OP_RESTORE: begin
        if (stk_empty) unf_set = 1'b1;
        else begin
          pop_en = 1'b1;
          sw_d   = stk_top;
        end
      end
      OP_SAVE: begin
        if (stk_full) ovf_set = 1'b1;
        else          push_en = 1'b1;
      end
      OP_WRITE: sw_d          = wr_data;
      OP_SET:   sw_d[bit_sel] = 1'b1;
      OP_CLR:   sw_d[bit_sel] = 1'b0;
      OP_EN:    sw_d[IE_POS]  = 1'b1;
      OP_DIS:   sw_d[IE_POS]  = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q      <= SW_RESET;
      ack_valid <= 1'b0;
      ack_index <= '0;
      ack_level <= '0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      sw_q      <= sw_d;
      ack_valid <= ack_d;
      if (ack_d) begin
        ack_index <= win_idx;
        ack_level <= win_lvl;
      end
      if (ovf_set) ovf_err <= 1'b1;
      if (unf_set) unf_err <= 1'b1;
    end
  end

  assign status_word = sw_q;
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker
  import irq_status_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_level,
  input logic [SW_W-1:0]  status_word,
  input logic             ovf_err,
  input logic             unf_err
);
  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid); // R6

  AST_ACK_WAS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(status_word[IE_POS]) &&
                   ack_level <= $past(status_word[THR_HI:THR_LO]))); // R5

  AST_ACK_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !status_word[IE_POS]); // R7

  AST_ACK_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (status_word[THR_HI:THR_LO] ==
                   ((ack_level == '0) ? 2'b00 : ack_level - 2'd1))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R10

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err); // R11

  AST_OVF_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> status_word == $past(status_word)); // R10

  AST_UNF_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_err) |-> status_word == $past(status_word)); // R11
endmodule

bind irq_status_unit irq_status_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_valid   (ack_valid),
  .ack_level   (ack_level),
  .status_word (status_word),
  .ovf_err     (ovf_err),
  .unf_err     (unf_err)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int NREQ = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NREQ-1:0] req_pending;
  logic [2*NREQ-1:0] req_level;
  logic ei_strobe, di_strobe, wr_en, bit_set, bit_clr, brk_strobe;
  logic push_strobe, pop_strobe, reti_strobe, retb_strobe;
  logic [7:0] wr_data;
  logic [2:0] bit_sel;
  logic       ack_valid, ovf_err, unf_err;
  logic [1:0] ack_index, ack_level;
  logic [7:0] status_word;

  irq_status_unit #(.NUM_REQ(NREQ), .STK_DEPTH(8)) uut (
    .clk, .rst_n, .req_pending, .req_level, .ei_strobe, .di_strobe,
    .wr_en, .wr_data, .bit_set, .bit_clr, .bit_sel, .brk_strobe,
    .push_strobe, .pop_strobe, .reti_strobe, .retb_strobe,
    .ack_valid, .ack_index, .ack_level, .status_word, .ovf_err, .unf_err
  );

  typedef struct packed { logic [1:0] idx; logic [1:0] lvl; } ack_t;
  ack_t expq[$];
  ack_t got;
  int checks = 0;
  int errors = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Scoreboard monitor: every acknowledge must match the next prediction.
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5/R6 unexpected ack actual=%0d/%0d expected=none", ack_index, ack_level);
      end else begin
        got = expq.pop_front();
        if (got.idx !== ack_index || got.lvl !== ack_level) begin
          errors++;
          $display("FAIL R6 ack idx/lvl actual=%0d/%0d expected=%0d/%0d",
                   ack_index, ack_level, got.idx, got.lvl);
        end
      end
    end
  end

  task automatic idle();
    req_pending = '0; req_level = '0; ei_strobe = 0; di_strobe = 0;
    wr_en = 0; wr_data = '0; bit_set = 0; bit_clr = 0; bit_sel = '0;
    brk_strobe = 0; push_strobe = 0; pop_strobe = 0; reti_strobe = 0; retb_strobe = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_write(input logic [7:0] d); wr_en = 1; wr_data = d; step(); endtask
  task automatic do_bit(input logic s, input logic [2:0] b);
    bit_sel = b; if (s) bit_set = 1; else bit_clr = 1; step();
  endtask
  task automatic do_ei(); ei_strobe = 1; step(); endtask
  task automatic do_di(); di_strobe = 1; step(); endtask
  task automatic do_brk(); brk_strobe = 1; step(); endtask
  task automatic do_push(); push_strobe = 1; step(); endtask
  task automatic do_pop(); pop_strobe = 1; step(); endtask
  task automatic do_reti(); reti_strobe = 1; step(); endtask
  task automatic do_retb(); retb_strobe = 1; step(); endtask

  // Driver: predicts the acknowledge (if any) and presents the requests.
  task automatic irq(input logic [3:0] pend, input logic [7:0] lv,
                     input logic expv, input logic [1:0] ei, input logic [1:0] el);
    if (expv) expq.push_back('{idx: ei, lvl: el});
    req_pending = pend; req_level = lv;
    step();
    if (!expv) chk({7'd0, ack_valid}, 8'd0, "R5 no ack");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(status_word, 8'h06, "R1 reset word");
    chk({5'd0, ack_valid, ovf_err, unf_err}, 8'd0, "R1 reset flags");

    // R2 whole-byte write
    do_write(8'h7B); chk(status_word, 8'h7B, "R2 write");
    do_write(8'h06); chk(status_word, 8'h06, "R2 write back");

    // R3 single bits
    do_bit(1, 3'd0); chk(status_word, 8'h07, "R3 set bit0");
    do_bit(0, 3'd2); chk(status_word, 8'h03, "R3 clr bit2");
    do_bit(1, 3'd7); chk(status_word, 8'h83, "R3 set bit7");
    do_bit(0, 3'd7); chk(status_word, 8'h03, "R3 clr bit7");
    do_bit(1, 3'd2); do_bit(0, 3'd0); chk(status_word, 8'h06, "R3 restore");

    // R4
    do_ei(); chk(status_word, 8'h86, "R4 enable");
    do_di(); chk(status_word, 8'h06, "R4 disable");

    // R5 enable off: nothing accepted
    irq(4'b0001, 8'h00, 0, 0, 0); chk(status_word, 8'h06, "R5 disabled word");
    do_ei();

    // R6 lowest level wins, tie to lowest index; R7 threshold level-1
    irq(4'b1110, {2'd1, 2'd1, 2'd2, 2'd0}, 1, 2'd2, 2'd1);
    chk(status_word, 8'h00, "R7 after level1 ack");
    do_ei(); chk(status_word, 8'h80, "R4 re-enable");
    irq(4'b0001, 8'h01, 0, 0, 0); chk(status_word, 8'h80, "R5 above threshold");
    irq(4'b0010, 8'h00, 1, 2'd1, 2'd0);
    chk(status_word, 8'h00, "R7 level0 ack threshold 00");

    // R9 nested returns in LIFO order
    do_reti(); chk(status_word, 8'h80, "R9 reti inner");
    do_retb(); chk(status_word, 8'h86, "R9 retb outer");

    // R7 level 3 accepted at threshold 11
    irq(4'b0010, {2'd0, 2'd0, 2'd3, 2'd0}, 1, 2'd1, 2'd3);
    chk(status_word, 8'h04, "R7 level3 ack");
    do_pop(); chk(status_word, 8'h86, "R9 pop");

    // R8 break
    do_brk(); chk(status_word, 8'h06, "R8 break");
    do_retb(); chk(status_word, 8'h86, "R8 return from break");

    // R9 save leaves word alone
    do_push(); chk(status_word, 8'h86, "R9 save");
    do_write(8'h55); do_pop(); chk(status_word, 8'h86, "R9 restore saved");

    // R11 underflow
    do_pop(); chk(status_word, 8'h86, "R11 word kept");
    chk({7'd0, unf_err}, 8'd1, "R11 underflow flag");
    do_write(8'h86); chk({7'd0, unf_err}, 8'd1, "R11 sticky");

    // R10 overflow
    for (int i = 0; i < 8; i++) do_push();
    chk({7'd0, ovf_err}, 8'd0, "R10 eight fit");
    do_push(); chk({7'd0, ovf_err}, 8'd1, "R10 overflow flag");
    chk(status_word, 8'h86, "R10 word kept on save");
    do_brk(); chk(status_word, 8'h86, "R10 break on full keeps word");
    irq(4'b0001, 8'h00, 0, 0, 0); chk(status_word, 8'h86, "R10 no ack when full");
    do_pop(); chk(status_word, 8'h86, "R10 pop");
    irq(4'b0001, 8'h00, 1, 2'd0, 2'd0); chk(status_word, 8'h00, "R10 ack after room");

    // R12 precedence
    pop_strobe = 1; wr_en = 1; wr_data = 8'h33; step();
    chk(status_word, 8'h86, "R12 restore beats write");
    wr_en = 1; wr_data = 8'h10; bit_set = 1; bit_sel = 3'd0; step();
    chk(status_word, 8'h10, "R12 write beats bit set");
    ei_strobe = 1; di_strobe = 1; step();
    chk(status_word, 8'h90, "R12 enable beats disable");
    expq.push_back('{idx: 2'd3, lvl: 2'd0});
    req_pending = 4'b1000; req_level = 8'h00; wr_en = 1; wr_data = 8'h22; step();
    chk(status_word, 8'h10, "R12 ack beats write");

    repeat (3) @(negedge clk);
    chk(8'(expq.size()), 8'd0, "R6 all predicted acks seen");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule